// File: doc/BRIEF.md
# Two-Tier Priority Interrupt Arbiter

This block collects a parameterised set of maskable interrupt sources, one non-maskable input and one address-break input. It presents a single winning request to a CPU core as a valid flag and a vector number. Each maskable source has a flag, an enable bit and a one-bit level bit. A source whose level bit is set belongs to the upper tier. Inside a tier, a fixed order decides, and the lowest index wins.

A global mask bit limits acceptance to the non-maskable and address-break requests. A request is accepted only on a cycle where the CPU signals an instruction boundary. On acceptance, the block saves the current mask, sets the mask, and holds the vector until the CPU acknowledges it. A return-from-interrupt strobe restores the saved mask. Software can also write the mask directly.

A 2-bit mode input selects the masking scheme. In the user-mask mode, an extra user bit joins the global mask.

Top module: `irq_tier_arbiter`

## Requirements
- R1: After synchronous reset, `irq_valid` is 0, `irq_vec` is 0 and `imask` is 1.
- R2: Maskable source i requests only while both `src_flag[i]` and `src_en[i]` are 1.
- R3: Any requesting maskable source with `src_lvl` 1 wins over every requesting source with `src_lvl` 0. The lower-tier requests stay pending.
- R4: Within the winning tier, the lowest source index wins. Maskable source i is reported as vector `VEC_BASE + i` (default 16 + i).
- R5: While the effective mask is 1, no maskable source is accepted, but the non-maskable and address-break requests still are.
- R6: A request is accepted only at a clock edge where `insn_end` is 1 and `irq_valid` is 0. `irq_valid` rises on that edge. `irq_vec` then stays unchanged until the edge where `irq_ack` is sampled 1, and `irq_valid` drops on that edge.
- R7: The acceptance edge sets `imask` to 1 and saves the value `imask` had just before that edge.
- R8: A rising edge on `nmi_in` and any cycle with `abrk_in` at 1 each latch a pending request. The order is non-maskable (vector `NMI_VEC`, default 2) first, then address-break (vector `ABRK_VEC`, default 3), then the maskable sources.
- R9: Acknowledge clears the latched non-maskable or address-break request if that request was the winner. A maskable request stays pending until its own flag is cleared.
- R10: `rte` loads `imask` from the saved value. `mask_wr` loads `imask` from `mask_wr_val`. Acceptance takes precedence over `rte`, and `rte` takes precedence over `mask_wr`.
- R11: With `mode` = 2'b10, `user_mask` = 1 also masks the maskable sources. In modes 2'b00, 2'b01 and 2'b11, `user_mask` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | NUM_SRC | Per-source interrupt flags |
| src_en | input | NUM_SRC | Per-source enable bits |
| src_lvl | input | NUM_SRC | Per-source tier bits (1 = upper tier) |
| nmi_in | input | 1 | Non-maskable input, rising-edge detected |
| abrk_in | input | 1 | Address-break request, latched while high |
| mode | input | 2 | Masking mode select |
| user_mask | input | 1 | User mask bit, used in mode 2'b10 |
| insn_end | input | 1 | Instruction-boundary strobe from the CPU |
| irq_ack | input | 1 | CPU acknowledge of the presented interrupt |
| rte | input | 1 | Return-from-interrupt strobe |
| mask_wr | input | 1 | Direct write strobe for the mask bit |
| mask_wr_val | input | 1 | Value for a direct mask write |
| irq_valid | output | 1 | An accepted interrupt is being presented |
| irq_vec | output | VEC_W | Vector number of the presented interrupt |
| imask | output | 1 | Global mask bit |

## Verification
The bench drives long stretches of mixed stimulus and compares the outputs against a behavioural model on every clock.

- **Simultaneous requests.** The stimulus makes requests from both tiers and several indices arrive together. A picker that ignored the tier bit, or scanned from the wrong end, would report the wrong vector.
- **Mask bit and its update sources.** Mask writes, return strobes and acceptances collide in the same cycle. A wrong precedence among them would leave `imask` at a value the model does not expect.
- **Pending requests across acknowledge.** Non-maskable edges arrive while another interrupt is presented. A latch cleared by any acknowledge, rather than only its own, would lose that request, and the model would flag the missing vector.
- **Mode-dependent user mask.** The user mask bit toggles in every mode. A design that honoured it outside the user-mask mode would block maskable vectors that the model accepts.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_NMI  = 2'd1,
    WIN_ABRK = 2'd2,
    WIN_SRC  = 2'd3
  } win_kind_e;

  localparam logic [1:0] MODE_USER_MASK = 2'b10;
endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] lvl,
  input  logic               allow,
  output logic [NUM_SRC-1:0] req_hi,
  output logic [NUM_SRC-1:0] req_lo
);
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      logic live;
      assign live      = flag[g] & en[g] & allow;
      assign req_hi[g] = live & lvl[g];
      assign req_lo[g] = live & ~lvl[g];
    end
  endgenerate
endmodule

// File: rtl/irq_fixed_pick.sv
module irq_fixed_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R4
  always_comb begin
    pick_is_request_chk: assert (!found || req[idx]);
  end
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic abrk_in,
  input  logic clr_nmi,
  input  logic clr_abrk,
  output logic nmi_pend,
  output logic abrk_pend
);
  logic nmi_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev  <= 1'b0;
      nmi_pend  <= 1'b0;
      abrk_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (nmi_in && !nmi_prev) nmi_pend <= 1'b1;
      else if (clr_nmi)        nmi_pend <= 1'b0;
      if (abrk_in)             abrk_pend <= 1'b1;
      else if (clr_abrk)       abrk_pend <= 1'b0;
    end
  end

  // R8
  nmi_edge_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (nmi_in && !nmi_prev) |=> nmi_pend);
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic rte,
  input  logic wr_en,
  input  logic wr_val,
  output logic imask
);
  logic saved;

  always_ff @(posedge clk) begin
    if (rst) begin
      imask <= 1'b1;
      saved <= 1'b1;
    end else if (accept) begin
      imask <= 1'b1;
      saved <= imask;
    end else if (rte) begin
      imask <= saved;
    end else if (wr_en) begin
      imask <= wr_val;
    end
  end

  // R7
  accept_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> imask);
  // R10
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !rte && wr_en) |=> (imask == $past(wr_val)));
endmodule

// File: rtl/irq_tier_arbiter.sv
module irq_tier_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 2,
  parameter int ABRK_VEC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               nmi_in,
  input  logic               abrk_in,
  input  logic [1:0]         mode,
  input  logic               user_mask,
  input  logic               insn_end,
  input  logic               irq_ack,
  input  logic               rte,
  input  logic               mask_wr,
  input  logic               mask_wr_val,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               imask
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               masked;
  logic [NUM_SRC-1:0] req_hi, req_lo;
  logic               hi_found, lo_found;
  logic [IDX_W-1:0]   hi_idx, lo_idx;
  logic               nmi_pend, abrk_pend;
  logic               any_req, accept, ack_fire;
  win_kind_e          win_kind, cur_kind;
  logic [VEC_W-1:0]   win_vec;

  assign masked = imask | ((mode == MODE_USER_MASK) & user_mask);

  irq_req_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .flag(src_flag), .en(src_en), .lvl(src_lvl), .allow(~masked),
    .req_hi(req_hi), .req_lo(req_lo)
  );

  irq_fixed_pick #(.NUM_SRC(NUM_SRC)) u_pick_hi (
    .req(req_hi), .found(hi_found), .idx(hi_idx)
  );

  irq_fixed_pick #(.NUM_SRC(NUM_SRC)) u_pick_lo (
    .req(req_lo), .found(lo_found), .idx(lo_idx)
  );

  assign ack_fire = irq_valid & irq_ack;

  irq_pend_latch u_pend (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .abrk_in(abrk_in),
    .clr_nmi(ack_fire && cur_kind == WIN_NMI),
    .clr_abrk(ack_fire && cur_kind == WIN_ABRK),
    .nmi_pend(nmi_pend), .abrk_pend(abrk_pend)
  );

  always_comb begin
    win_kind = WIN_NONE;
    win_vec  = '0;
    if (nmi_pend) begin
      win_kind = WIN_NMI;
      win_vec  = VEC_W'(NMI_VEC);
    end else if (abrk_pend) begin
      win_kind = WIN_ABRK;
      win_vec  = VEC_W'(ABRK_VEC);
    end else if (hi_found) begin
      win_kind = WIN_SRC;
      win_vec  = VEC_W'(VEC_BASE) + VEC_W'(hi_idx);
    end else if (lo_found) begin
      win_kind = WIN_SRC;
      win_vec  = VEC_W'(VEC_BASE) + VEC_W'(lo_idx);
    end
  end

  assign any_req = (win_kind != WIN_NONE);
  assign accept  = !irq_valid && insn_end && any_req;

  irq_mask_ctl u_mask (
    .clk(clk), .rst(rst), .accept(accept), .rte(rte),
    .wr_en(mask_wr), .wr_val(mask_wr_val), .imask(imask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      cur_kind  <= WIN_NONE;
    end else if (accept) begin
      irq_valid <= 1'b1;
      irq_vec   <= win_vec;
      cur_kind  <= win_kind;
    end else if (ack_fire) begin
      irq_valid <= 1'b0;
    end
  end

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vec)));
  // R6
  accept_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(insn_end));
  // R5
  mask_blocks_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_valid) && $past(masked)) |-> (cur_kind != WIN_SRC));
  // R7
  mask_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> imask);
  // R9
  ack_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> !irq_valid);
endmodule

// File: tb/tb_irq_tier_arbiter.sv
module tb_irq_tier_arbiter;
  localparam int N = 8;
  localparam int VB = 16;
  localparam int NV = 2;
  localparam int AV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_flag = '0, src_en = '0, src_lvl = '0;
  logic nmi_in = 0, abrk_in = 0, user_mask = 0, insn_end = 0;
  logic irq_ack = 0, rte = 0, mask_wr = 0, mask_wr_val = 0;
  logic [1:0] mode = 2'b00;
  logic irq_valid, imask;
  logic [7:0] irq_vec;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model state
  bit m_valid, m_imask, m_saved, m_nmi_prev, m_nmi_pend, m_abrk_pend;
  int m_vec, m_kind; // kind: 0 none, 1 nmi, 2 abrk, 3 source

  always #2 clk = ~clk;

  irq_tier_arbiter dut (
    .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
    .src_lvl(src_lvl), .nmi_in(nmi_in), .abrk_in(abrk_in), .mode(mode),
    .user_mask(user_mask), .insn_end(insn_end), .irq_ack(irq_ack),
    .rte(rte), .mask_wr(mask_wr), .mask_wr_val(mask_wr_val),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .imask(imask)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_imask = 1; m_saved = 1; m_nmi_prev = 0;
    m_nmi_pend = 0; m_abrk_pend = 0; m_vec = 0; m_kind = 0;
  endtask

  task automatic model_step();
    bit msk, acc, ackf;
    int wk, wv, hi, lo;
    msk = m_imask || (mode == 2'b10 && user_mask);
    hi = -1; lo = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!msk && src_flag[i] && src_en[i]) begin
        if (src_lvl[i]) hi = i; else lo = i;
      end
    end
    wk = 0; wv = 0;
    if (m_nmi_pend)       begin wk = 1; wv = NV; end
    else if (m_abrk_pend) begin wk = 2; wv = AV; end
    else if (hi >= 0)     begin wk = 3; wv = VB + hi; end
    else if (lo >= 0)     begin wk = 3; wv = VB + lo; end
    acc  = !m_valid && insn_end && wk != 0;
    ackf = m_valid && irq_ack;
    if (nmi_in && !m_nmi_prev) m_nmi_pend = 1;
    else if (ackf && m_kind == 1) m_nmi_pend = 0;
    if (abrk_in) m_abrk_pend = 1;
    else if (ackf && m_kind == 2) m_abrk_pend = 0;
    m_nmi_prev = nmi_in;
    if (acc) begin m_saved = m_imask; m_imask = 1; end
    else if (rte) m_imask = m_saved;
    else if (mask_wr) m_imask = mask_wr_val;
    if (acc) begin m_valid = 1; m_vec = wv; m_kind = wk; end
    else if (ackf) m_valid = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    #1;
    check(tag, "irq_valid", irq_valid, m_valid);
    check(tag, "irq_vec", irq_vec, m_vec);
    check(tag, "imask", imask, m_imask);
  endtask

  task automatic phase(string tag, int n, bit use_lvl, bit use_nmi,
                       bit use_abrk, logic [1:0] md, int wr_one_pct);
    mode = md;
    for (int c = 0; c < n; c++) begin
      int vi;
      src_flag = src_flag | N'($urandom & $urandom & $urandom);
      src_en   = N'($urandom | $urandom);
      src_lvl  = use_lvl ? N'($urandom) : '0;
      nmi_in   = use_nmi ? ($urandom % 4 == 0) : 1'b0;
      abrk_in  = use_abrk ? ($urandom % 12 == 0) : 1'b0;
      user_mask = $urandom % 2;
      insn_end = ($urandom % 3 == 0);
      irq_ack  = irq_valid && ($urandom % 2 == 0);
      if (irq_ack && irq_vec >= VB) begin
        vi = int'(irq_vec) - VB;
        src_flag[vi] = 1'b0;
      end
      rte = ($urandom % 5 == 0);
      mask_wr = ($urandom % 3 == 0);
      mask_wr_val = (($urandom % 100) < wr_one_pct);
      step(tag);
    end
  endtask

  initial begin
    model_reset();
    rst = 1;
    step("R1");
    step("R1");
    rst = 0;
    #1;
    check("R1", "irq_valid after reset", irq_valid, 0);
    check("R1", "irq_vec after reset", irq_vec, 0);
    check("R1", "imask after reset", imask, 1);

    // R2: flags without enable do not request, then enabling does
    mask_wr = 1; mask_wr_val = 0; step("R2");
    mask_wr = 0;
    src_flag = 8'hF0; src_en = 8'h0F; insn_end = 1; step("R2");
    check("R2", "no request without enable", irq_valid, 0);
    src_en = 8'hFF; step("R2");
    check("R2", "enabled source 4 vector", irq_vec, VB + 4);
    insn_end = 0; irq_ack = 1; src_flag = '0; step("R9");
    irq_ack = 0; rte = 1; step("R10");
    rte = 0;
    check("R10", "rte restores saved mask 0", imask, 0);

    // R3: upper tier beats a lower index in the lower tier
    src_flag = 8'h21; src_en = 8'hFF; src_lvl = 8'h20; insn_end = 1; step("R3");
    check("R3", "upper tier vector", irq_vec, VB + 5);
    insn_end = 0; irq_ack = 1; src_flag = 8'h01; step("R9");
    irq_ack = 0; rte = 1; step("R10");
    rte = 0; insn_end = 1; step("R9");
    check("R9", "pending lower tier taken next", irq_vec, VB + 0);
    insn_end = 0; irq_ack = 1; src_flag = '0; step("R9");
    irq_ack = 0; src_lvl = '0;

    phase("R2", 2000, 0, 0, 0, 2'b00, 10);
    phase("R3", 3000, 1, 0, 0, 2'b00, 10);
    phase("R4", 3000, 1, 0, 0, 2'b00, 5);
    phase("R5", 3000, 1, 1, 1, 2'b00, 60);
    phase("R6", 2000, 1, 1, 0, 2'b00, 20);
    phase("R7", 2000, 1, 0, 1, 2'b00, 20);
    phase("R8", 3000, 1, 1, 1, 2'b00, 20);
    phase("R9", 3000, 1, 1, 1, 2'b00, 15);
    phase("R10", 3000, 1, 0, 0, 2'b00, 40);
    phase("R11", 3000, 1, 1, 0, 2'b10, 10);
    phase("R11", 2000, 1, 0, 0, 2'b01, 10);
    phase("R11", 2000, 1, 0, 0, 2'b11, 10);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule